// File: doc/BRIEF.md
# PWM Shadow Register Reload Controller

This block sits beside a PWM counter and decides when the values that software has staged become the values the counter actually runs with. The staged set holds a prescaler code, a counter start value and a bank of compare values. Software writes the staged set, then raises a load-enable bit. From then on the staged set is copied into the working set at the next qualifying reload point, and load-enable drops by itself.

A reload point comes from one of two places. The first is the local counter, on half-cycle events, full-cycle events or both, thinned out by a programmable divider. The second is a reload strobe from a reference channel, which lets several channels switch at the same instant. There is also an immediate mode, where the copy happens as soon as load-enable is seen.

Every reload point raises a sticky reload flag and a one-cycle strobe. A reload point that finds load-enable clear while the staged set holds unsent writes raises a sticky error flag instead of copying. Both flags are cleared by writing a one.

Top module: `pwm_reload_ctrl`

## Requirements
- R1: After reset, every working register is zero, and load-enable, the reload strobe, the reload flag and the error flag are all low.
- R2: The working registers (prescaler, start value, compare bank) change only at a transfer. A transfer is a reload point seen while load-enable is high, and it copies the staged values present in that same cycle.
- R3: With `cfg_point` = 0 and the local source selected, a reload point occurs in every cycle in which load-enable is high. The working set therefore takes the staged values one cycle after `ldok` reads high.
- R4: With the local source selected, `cfg_point` picks the reload opportunity: 1 is a `half_evt` strobe, 2 is a `full_evt` strobe, and 3 is either of the two.
- R5: The local source gives a reload point only on the (`cfg_freq`+1)-th opportunity. An internal opportunity count runs from 0 and wraps to 0 once it has reached `cfg_freq`. A `ldok_set` pulse zeroes this count, so the first transfer waits a full `cfg_freq`+1 opportunities.
- R6: With `cfg_master` = 1, the reload points are exactly the cycles with `master_reload` high, and half-cycle and full-cycle events are ignored. A transfer still needs the local load-enable to be high.
- R7: `ldok_clr` drops load-enable on the next cycle without any transfer, and it wins over a `ldok_set` in the same cycle.
- R8: Load-enable clears by itself on the cycle after a transfer, unless `ldok_set` is pulsed in the transfer cycle, in which case it stays high.
- R9: Each reload point gives a one-cycle `reload_stb` on the next cycle and sets `reload_flag`. Writing one to `flag_clr[0]` clears the flag, but a reload point in the same cycle wins over the clear.
- R10: `err_flag` sets on the cycle after a reload point that finds load-enable low while a staged write (`shd_wr`) has happened since the last transfer. A transfer clears this pending-write state. Writing one to `flag_clr[1]` clears the error flag, and setting wins over clearing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ldok_set | input | 1 | Pulse that raises load-enable |
| ldok_clr | input | 1 | Pulse that drops load-enable without transfer |
| half_evt | input | 1 | Half-cycle event strobe from the counter |
| full_evt | input | 1 | Full-cycle event strobe from the counter |
| master_reload | input | 1 | Reload strobe from the reference channel |
| cfg_point | input | 2 | Reload opportunity select: 0 immediate, 1 half, 2 full, 3 both |
| cfg_freq | input | FW | Reload on every (value+1)-th opportunity |
| cfg_master | input | 1 | 1 selects the reference channel strobe as the reload source |
| shd_wr | input | 1 | Marks a write to the staged set this cycle |
| shd_presc | input | PSW | Staged prescaler code |
| shd_init | input | DW | Staged counter start value |
| shd_val | input | NVAL*DW | Staged compare bank, entry i in bits [i*DW +: DW] |
| flag_clr | input | 2 | Write-one-to-clear: bit 0 reload flag, bit 1 error flag |
| act_presc | output | PSW | Working prescaler code |
| act_init | output | DW | Working counter start value |
| act_val | output | NVAL*DW | Working compare bank |
| ldok | output | 1 | Current load-enable state |
| reload_stb | output | 1 | One-cycle pulse after each reload point |
| reload_flag | output | 1 | Sticky reload flag |
| err_flag | output | 1 | Sticky reload-error flag |

## Verification
The bench builds the block with 8-bit values, three compare entries, a 3-bit prescaler and a 4-bit divider field. Narrow words keep the compare bank short. The divider field still has its full 0..15 range, so both the largest divide ratio and the wrap of the opportunity count can be reached inside a short run. Random traffic mostly draws small divide values, so that reloads, errors, and races between set, clear and transfer come up often. Directed sequences cover exact transfer cycles for each reload point code and for the reference-channel source.

// File: rtl/pwm_reload_ctrl.sv
module pwm_reload_ctrl #(
  parameter int DW   = 16,
  parameter int NVAL = 6,
  parameter int PSW  = 3,
  parameter int FW   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ldok_set,
  input  logic               ldok_clr,
  input  logic               half_evt,
  input  logic               full_evt,
  input  logic               master_reload,
  input  logic [1:0]         cfg_point,
  input  logic [FW-1:0]      cfg_freq,
  input  logic               cfg_master,
  input  logic               shd_wr,
  input  logic [PSW-1:0]     shd_presc,
  input  logic [DW-1:0]      shd_init,
  input  logic [NVAL*DW-1:0] shd_val,
  input  logic [1:0]         flag_clr,
  output logic [PSW-1:0]     act_presc,
  output logic [DW-1:0]      act_init,
  output logic [NVAL*DW-1:0] act_val,
  output logic               ldok,
  output logic               reload_stb,
  output logic               reload_flag,
  output logic               err_flag
);

  localparam int VW = NVAL * DW;

  logic [FW-1:0] opp_cnt;
  logic          dirty;

  // reload opportunity from the local counter
  wire opp_hit  = (cfg_point == 2'd1 && half_evt) ||
                  (cfg_point == 2'd2 && full_evt) ||
                  (cfg_point == 2'd3 && (half_evt || full_evt));
  wire cnt_full = opp_cnt >= cfg_freq;
  wire local_pt = (cfg_point == 2'd0) ? ldok : (opp_hit && cnt_full);
  wire rpt      = cfg_master ? master_reload : local_pt;
  wire xfer     = rpt && ldok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opp_cnt <= '0;
    end else if (ldok_set) begin
      opp_cnt <= '0;
    end else if (opp_hit) begin
      opp_cnt <= cnt_full ? '0 : opp_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ldok <= 1'b0;
    end else if (ldok_clr) begin
      ldok <= 1'b0;
    end else if (ldok_set) begin
      ldok <= 1'b1;
    end else if (xfer) begin
      ldok <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_presc <= '0;
      act_init  <= '0;
      act_val   <= '0;
    end else if (xfer) begin
      act_presc <= shd_presc;
      act_init  <= shd_init;
      act_val   <= shd_val[VW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dirty       <= 1'b0;
      reload_stb  <= 1'b0;
      reload_flag <= 1'b0;
      err_flag    <= 1'b0;
    end else begin
      dirty       <= shd_wr || (dirty && !xfer);
      reload_stb  <= rpt;
      reload_flag <= rpt || (reload_flag && !flag_clr[0]);
      err_flag    <= (rpt && !ldok && dirty) || (err_flag && !flag_clr[1]);
    end
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ldok |=> ($stable(act_val) && $stable(act_init) && $stable(act_presc)));

  p_clr_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ldok_clr |=> !ldok);

  p_autoclr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !ldok_set) |=> !ldok);

  p_master_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && !master_reload) |=> !reload_stb);

  p_stb_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reload_stb |-> reload_flag);

  p_err_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> ($past(!ldok) && $past(dirty)));

endmodule

// File: tb/sim_pwm_reload_ctrl.sv
`timescale 1ns/1ps
module sim_pwm_reload_ctrl;
  localparam int DW = 8, NVAL = 3, PSW = 3, FW = 4;
  localparam int VW = NVAL * DW;

  logic clk = 0, rst_n = 0;
  logic ldok_set = 0, ldok_clr = 0, half_evt = 0, full_evt = 0, master_reload = 0;
  logic [1:0] cfg_point = 0;
  logic [FW-1:0] cfg_freq = 0;
  logic cfg_master = 0, shd_wr = 0;
  logic [PSW-1:0] shd_presc = 0;
  logic [DW-1:0] shd_init = 0;
  logic [VW-1:0] shd_val = 0;
  logic [1:0] flag_clr = 0;
  logic [PSW-1:0] act_presc;
  logic [DW-1:0] act_init;
  logic [VW-1:0] act_val;
  logic ldok, reload_stb, reload_flag, err_flag;

  int checks = 0, fails = 0;

  // reference state
  logic [PSW-1:0] m_presc;
  logic [DW-1:0] m_init;
  logic [VW-1:0] m_val;
  logic m_ldok, m_stb, m_flag, m_err, m_dirty;
  logic [FW-1:0] m_cnt;

  always #2.5 clk = ~clk;

  pwm_reload_ctrl #(.DW(DW), .NVAL(NVAL), .PSW(PSW), .FW(FW)) u0 (
    .clk(clk), .rst_n(rst_n), .ldok_set(ldok_set), .ldok_clr(ldok_clr),
    .half_evt(half_evt), .full_evt(full_evt), .master_reload(master_reload),
    .cfg_point(cfg_point), .cfg_freq(cfg_freq), .cfg_master(cfg_master),
    .shd_wr(shd_wr), .shd_presc(shd_presc), .shd_init(shd_init), .shd_val(shd_val),
    .flag_clr(flag_clr), .act_presc(act_presc), .act_init(act_init), .act_val(act_val),
    .ldok(ldok), .reload_stb(reload_stb), .reload_flag(reload_flag), .err_flag(err_flag));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic opp_of();
    return (cfg_point == 2'd1 && half_evt) || (cfg_point == 2'd2 && full_evt) ||
           (cfg_point == 2'd3 && (half_evt || full_evt));
  endfunction

  task automatic model_step();
    logic opp, rpt, xf;
    opp = opp_of();
    if (cfg_master) rpt = master_reload;
    else if (cfg_point == 2'd0) rpt = m_ldok;
    else rpt = opp && (m_cnt >= cfg_freq);
    xf = rpt && m_ldok;
    if (xf) begin m_presc = shd_presc; m_init = shd_init; m_val = shd_val; end
    m_err   = (rpt && !m_ldok && m_dirty) || (m_err && !flag_clr[1]);
    m_flag  = rpt || (m_flag && !flag_clr[0]);
    m_stb   = rpt;
    m_dirty = shd_wr || (m_dirty && !xf);
    m_ldok  = ldok_clr ? 1'b0 : ldok_set ? 1'b1 : xf ? 1'b0 : m_ldok;
    if (ldok_set) m_cnt = '0;
    else if (opp) m_cnt = (m_cnt >= cfg_freq) ? '0 : m_cnt + 1'b1;
  endtask

  task automatic compare_all();
    chk("R2 act_presc", 64'(act_presc), 64'(m_presc));
    chk("R2 act_init", 64'(act_init), 64'(m_init));
    chk("R2 act_val", 64'(act_val), 64'(m_val));
    chk("R8 ldok", 64'(ldok), 64'(m_ldok));
    chk("R9 reload_stb", 64'(reload_stb), 64'(m_stb));
    chk("R9 reload_flag", 64'(reload_flag), 64'(m_flag));
    chk("R10 err_flag", 64'(err_flag), 64'(m_err));
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    ldok_set = 0; ldok_clr = 0; half_evt = 0; full_evt = 0;
    master_reload = 0; shd_wr = 0; flag_clr = 0;
  endtask

  task automatic stage(input logic [DW-1:0] base);
    shd_wr = 1; shd_presc = base[PSW-1:0]; shd_init = base;
    shd_val = {base + 8'd2, base + 8'd1, base};
  endtask

  task automatic idle_clear();
    cfg_master = 0; cfg_point = 2'd2; ldok_clr = 1; flag_clr = 2'b11; tick();
    flag_clr = 2'b11; tick();
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    m_presc = 0; m_init = 0; m_val = 0; m_ldok = 0; m_stb = 0;
    m_flag = 0; m_err = 0; m_dirty = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 act_val", 64'(act_val), 0);
    chk("R1 act_init", 64'(act_init), 0);
    chk("R1 ldok", 64'(ldok), 0);
    chk("R1 flags", 64'({reload_stb, reload_flag, err_flag}), 0);

    // R3 immediate mode
    cfg_point = 2'd0; stage(8'h31); ldok_set = 1; tick();
    chk("R3 ldok high", 64'(ldok), 1);
    chk("R3 no copy yet", 64'(act_init), 0);
    tick();
    chk("R3 copied", 64'(act_init), 64'h31);
    chk("R8 auto clear", 64'(ldok), 0);
    idle_clear();

    // R4 half only with code 1
    cfg_point = 2'd1; cfg_freq = 0; stage(8'h52); ldok_set = 1; tick();
    full_evt = 1; tick();
    chk("R4 full ignored in half mode", 64'(act_init), 64'h31);
    half_evt = 1; tick();
    chk("R4 half reload", 64'(act_init), 64'h52);
    idle_clear();

    // R5 divide by three with full events
    cfg_point = 2'd2; cfg_freq = 4'd2; stage(8'h6a); ldok_set = 1; tick();
    full_evt = 1; tick();
    full_evt = 1; tick();
    chk("R5 held before 3rd", 64'(act_init), 64'h52);
    full_evt = 1; tick();
    chk("R5 third opportunity", 64'(act_init), 64'h6a);
    idle_clear();

    // R6 master source
    cfg_freq = 0; cfg_point = 2'd3; stage(8'h77); ldok_set = 1; tick();
    cfg_master = 1; full_evt = 1; half_evt = 1; tick();
    chk("R6 local events ignored", 64'(act_init), 64'h6a);
    chk("R6 no stb", 64'(reload_stb), 0);
    master_reload = 1; tick();
    chk("R6 master reload", 64'(act_init), 64'h77);
    idle_clear();

    // R7 clear wins over set, no transfer
    cfg_point = 2'd0; stage(8'h88); ldok_set = 1; ldok_clr = 1; tick();
    chk("R7 clr wins", 64'(ldok), 0);
    tick(); tick();
    chk("R7 no transfer", 64'(act_init), 64'h77);

    // R10 error flag
    cfg_point = 2'd2; full_evt = 1; tick();
    chk("R10 error set", 64'(err_flag), 1);
    flag_clr = 2'b10; tick();
    chk("R10 error cleared", 64'(err_flag), 0);

    // random phase
    for (int i = 0; i < 6000; i++) begin
      if (i % 64 == 0) begin
        cfg_point = 2'($urandom_range(0, 3));
        cfg_master = ($urandom_range(0, 3) == 0);
        cfg_freq = ($urandom_range(0, 7) == 0) ? 4'd15 : 4'($urandom_range(0, 3));
      end
      ldok_set = ($urandom_range(0, 7) == 0);
      ldok_clr = ($urandom_range(0, 31) == 0);
      half_evt = ($urandom_range(0, 2) == 0);
      full_evt = ($urandom_range(0, 3) == 0);
      master_reload = ($urandom_range(0, 5) == 0);
      if ($urandom_range(0, 3) == 0) stage(8'($urandom()));
      flag_clr = 2'($urandom_range(0, 3)) & {($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0)};
      tick();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule